// File: doc/BRIEF.md
# PTP Event Message Timestamp Capture

This block watches the receive and transmit byte streams of one Ethernet port for precision-time-protocol event messages. At the start of every frame it copies a free-running 64-bit time value into a holding register. At that moment the message type is not yet known. The block then parses the frame. When the frame ends cleanly and its message type is the one that the port's clock role selects for that direction, the held time moves into a capture register set. The sender's 48-bit UUID and the 16-bit sequence number are captured with it. Receive and transmit each have their own capture set, a sticky valid flag and an overrun flag. The host clears both flags with write-one-to-clear pulses.

Each stream is a byte interface with a valid strobe, plus two single-cycle strobes. The frame-start strobe is raised in the cycle of the timestamp point, which is the first data bit after the start-of-frame delimiter. The end strobe carries an error qualifier. The block never applies back-pressure. Its ready outputs are held high, so a byte is accepted in every cycle its valid is high. A byte presented in the same cycle as a frame-start or end strobe is not part of the frame. The parameter `HOST_SIDE` swaps the receive and transmit roles. This suits a port facing the switch fabric, where "receive" means data coming from the fabric.

Top module: `ptp_ts_capture`

## Requirements
- R1: A capture's time field equals the `time_now` value sampled in the cycle in which that frame's start strobe was high.
- R2: With `mode_master`=0 (slave), a Sync message (type 0) on the receive-role stream triggers capture, and so does a Delay_Req message (type 1) on the transmit-role stream.
- R3: With `mode_master`=1 (master), a Delay_Req message (type 1) on the receive-role stream triggers capture, and so does a Sync message (type 0) on the transmit-role stream.
- R4: Types 2 (Follow_Up), 3 (Delay_Resp), 4 (Management) and every other value never trigger capture. They leave the capture registers and flags unchanged.
- R5: Byte offset 0 is the first byte accepted after the start strobe, and only cycles with valid high advance the offset. The message type is the low 4 bits of the byte at offset `MT_OFS` (default 0). The UUID is read big-endian from offsets `UUID_OFS`..`UUID_OFS`+5 (default 22). The sequence ID is read big-endian from offsets `SEQ_OFS`..`SEQ_OFS`+1 (default 30).
- R6: The capture registers change only in the cycle after an end strobe. An end strobe with error high, or one that arrives before the last parsed byte has been seen, discards the held value.
- R7: A start strobe during an open frame restarts parsing, and it takes a new time snapshot.
- R8: A capture while that direction's valid flag is set overwrites the registers and sets the overrun flag.
- R9: Clear bit 0 clears the valid flag and clear bit 1 clears the overrun flag. Both act one cycle later.
- R10: With `HOST_SIDE`=1, the `rx_*` stream follows the transmit-role rules and the `tx_*` stream follows the receive-role rules.
- R11: After reset, both flags and all capture registers are zero in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_master | input | 1 | Clock role: 1 master, 0 slave |
| time_now | input | TIME_W | Free-running time value |
| rx_sfd | input | 1 | Receive frame-start strobe (timestamp point) |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Receive ready, always high |
| rx_data | input | 8 | Receive byte |
| rx_eof | input | 1 | Receive end-of-frame strobe |
| rx_err | input | 1 | Receive frame error, qualifies rx_eof |
| rx_clr | input | 2 | Receive W1C: bit 0 valid, bit 1 overrun |
| rx_cap_valid | output | 1 | Receive capture present |
| rx_cap_ovr | output | 1 | Receive capture overwritten |
| rx_cap_time | output | TIME_W | Receive captured time |
| rx_cap_uuid | output | 48 | Receive captured UUID |
| rx_cap_seq | output | 16 | Receive captured sequence ID |
| tx_sfd | input | 1 | Transmit frame-start strobe |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Transmit ready, always high |
| tx_data | input | 8 | Transmit byte |
| tx_eof | input | 1 | Transmit end-of-frame strobe |
| tx_err | input | 1 | Transmit frame error |
| tx_clr | input | 2 | Transmit W1C: bit 0 valid, bit 1 overrun |
| tx_cap_valid | output | 1 | Transmit capture present |
| tx_cap_ovr | output | 1 | Transmit capture overwritten |
| tx_cap_time | output | TIME_W | Transmit captured time |
| tx_cap_uuid | output | 48 | Transmit captured UUID |
| tx_cap_seq | output | 16 | Transmit captured sequence ID |

## Verification
The bench sweeps all sixteen type codes against both roles, both directions, both values of `HOST_SIDE` and the error bit. A swapped role table would capture on the wrong direction. A loose type compare would capture Follow_Up or Management frames. Frames with a valid gap, frames that end one byte short and frames restarted mid-way expose a counter that counts idle cycles, a commit that skips the length check, and a snapshot that is not re-taken. Back-to-back captures and single-bit clears show whether overrun and the two flags are kept apart.

// File: rtl/ptp_ts_pkg.sv
package ptp_ts_pkg;
  localparam logic [3:0] MSG_SYNC       = 4'd0;
  localparam logic [3:0] MSG_DELAY_REQ  = 4'd1;
  localparam logic [3:0] MSG_FOLLOW_UP  = 4'd2;
  localparam logic [3:0] MSG_DELAY_RESP = 4'd3;
  localparam logic [3:0] MSG_MGMT       = 4'd4;

  // tx_role = 1 means the stream is treated as the transmit direction
  function automatic logic [3:0] wanted_type(input logic master, input logic tx_role);
    return (master ^ tx_role) ? MSG_DELAY_REQ : MSG_SYNC;
  endfunction
endpackage

// File: rtl/ptp_frame_parser.sv
module ptp_frame_parser #(
  parameter int TIME_W   = 64,
  parameter int MT_OFS   = 0,
  parameter int UUID_OFS = 22,
  parameter int SEQ_OFS  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_now,
  input  logic              sfd,
  input  logic              valid,
  input  logic [7:0]        data,
  input  logic              eof,
  output logic              active,
  output logic              complete,
  output logic [3:0]        msg_type,
  output logic [47:0]       uuid,
  output logic [15:0]       seq,
  output logic [TIME_W-1:0] hold
);
  localparam int UUID_END = UUID_OFS + 5;
  localparam int SEQ_END  = SEQ_OFS + 1;
  localparam int LAST_A   = (UUID_END > SEQ_END) ? UUID_END : SEQ_END;
  localparam int LAST     = (LAST_A > MT_OFS) ? LAST_A : MT_OFS;
  localparam int NEED     = LAST + 1;
  localparam int CW       = $clog2(NEED + 1);
  localparam logic [CW-1:0] NEED_C = CW'(NEED);
  localparam logic [CW-1:0] MT_C   = CW'(MT_OFS);
  localparam logic [CW-1:0] UU_LO  = CW'(UUID_OFS);
  localparam logic [CW-1:0] UU_HI  = CW'(UUID_END);
  localparam logic [CW-1:0] SQ_LO  = CW'(SEQ_OFS);
  localparam logic [CW-1:0] SQ_HI  = CW'(SEQ_END);

  logic [CW-1:0] cnt;

  assign complete = (cnt == NEED_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cnt      <= '0;
      msg_type <= '0;
      uuid     <= '0;
      seq      <= '0;
      hold     <= '0;
    end else if (sfd) begin
      active <= 1'b1;
      cnt    <= '0;
      hold   <= time_now;
    end else if (eof) begin
      active <= 1'b0;
    end else if (valid && active) begin
      if (cnt != NEED_C) cnt <= cnt + 1'b1;
      if (cnt == MT_C) msg_type <= data[3:0];
      if (cnt >= UU_LO && cnt <= UU_HI) uuid <= {uuid[39:0], data};
      if (cnt >= SQ_LO && cnt <= SQ_HI) seq <= {seq[7:0], data};
    end
  end
endmodule

// File: rtl/ptp_capture_bank.sv
module ptp_capture_bank #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [1:0]        clr,
  input  logic [TIME_W-1:0] in_time,
  input  logic [47:0]       in_uuid,
  input  logic [15:0]       in_seq,
  output logic              cap_valid,
  output logic              cap_ovr,
  output logic [TIME_W-1:0] cap_time,
  output logic [47:0]       cap_uuid,
  output logic [15:0]       cap_seq
);
  logic still_set;
  assign still_set = cap_valid & ~clr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      cap_ovr   <= 1'b0;
      cap_time  <= '0;
      cap_uuid  <= '0;
      cap_seq   <= '0;
    end else begin
      cap_valid <= commit | still_set;
      cap_ovr   <= (cap_ovr & ~clr[1]) | (commit & still_set);
      if (commit) begin
        cap_time <= in_time;
        cap_uuid <= in_uuid;
        cap_seq  <= in_seq;
      end
    end
  end
endmodule

// File: rtl/ptp_ts_capture.sv
module ptp_ts_capture #(
  parameter int TIME_W    = 64,
  parameter int MT_OFS    = 0,
  parameter int UUID_OFS  = 22,
  parameter int SEQ_OFS   = 30,
  parameter bit HOST_SIDE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_master,
  input  logic [TIME_W-1:0] time_now,
  input  logic              rx_sfd,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_eof,
  input  logic              rx_err,
  input  logic [1:0]        rx_clr,
  output logic              rx_cap_valid,
  output logic              rx_cap_ovr,
  output logic [TIME_W-1:0] rx_cap_time,
  output logic [47:0]       rx_cap_uuid,
  output logic [15:0]       rx_cap_seq,
  input  logic              tx_sfd,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [7:0]        tx_data,
  input  logic              tx_eof,
  input  logic              tx_err,
  input  logic [1:0]        tx_clr,
  output logic              tx_cap_valid,
  output logic              tx_cap_ovr,
  output logic [TIME_W-1:0] tx_cap_time,
  output logic [47:0]       tx_cap_uuid,
  output logic [15:0]       tx_cap_seq
);
  import ptp_ts_pkg::*;

  localparam int NDIR = 2;

  logic [NDIR-1:0]   sfd_a, valid_a, eof_a, err_a, cv_a, co_a;
  logic [7:0]        data_a [NDIR];
  logic [1:0]        clr_a  [NDIR];
  logic [TIME_W-1:0] ct_a   [NDIR];
  logic [47:0]       cu_a   [NDIR];
  logic [15:0]       cs_a   [NDIR];

  assign sfd_a   = {tx_sfd, rx_sfd};
  assign valid_a = {tx_valid, rx_valid};
  assign eof_a   = {tx_eof, rx_eof};
  assign err_a   = {tx_err, rx_err};
  assign data_a[0] = rx_data;
  assign data_a[1] = tx_data;
  assign clr_a[0]  = rx_clr;
  assign clr_a[1]  = tx_clr;

  assign rx_ready = 1'b1;
  assign tx_ready = 1'b1;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    localparam bit TX_ROLE = (d == 1) ^ HOST_SIDE;

    logic              active, complete, commit;
    logic [3:0]        msg_type;
    logic [47:0]       uuid;
    logic [15:0]       seq;
    logic [TIME_W-1:0] hold;

    ptp_frame_parser #(
      .TIME_W(TIME_W), .MT_OFS(MT_OFS), .UUID_OFS(UUID_OFS), .SEQ_OFS(SEQ_OFS)
    ) u_parse (
      .clk(clk), .rst_n(rst_n), .time_now(time_now),
      .sfd(sfd_a[d]), .valid(valid_a[d]), .data(data_a[d]), .eof(eof_a[d]),
      .active(active), .complete(complete), .msg_type(msg_type),
      .uuid(uuid), .seq(seq), .hold(hold)
    );

    assign commit = eof_a[d] & ~sfd_a[d] & active & complete & ~err_a[d] &
                    (msg_type == wanted_type(mode_master, TX_ROLE));

    ptp_capture_bank #(.TIME_W(TIME_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .commit(commit), .clr(clr_a[d]),
      .in_time(hold), .in_uuid(uuid), .in_seq(seq),
      .cap_valid(cv_a[d]), .cap_ovr(co_a[d]),
      .cap_time(ct_a[d]), .cap_uuid(cu_a[d]), .cap_seq(cs_a[d])
    );
  end

  assign rx_cap_valid = cv_a[0];
  assign rx_cap_ovr   = co_a[0];
  assign rx_cap_time  = ct_a[0];
  assign rx_cap_uuid  = cu_a[0];
  assign rx_cap_seq   = cs_a[0];
  assign tx_cap_valid = cv_a[1];
  assign tx_cap_ovr   = co_a[1];
  assign tx_cap_time  = ct_a[1];
  assign tx_cap_uuid  = cu_a[1];
  assign tx_cap_seq   = cs_a[1];
endmodule

// File: rtl/ptp_ts_capture_chk.sv
module ptp_ts_capture_chk #(
  parameter int TIME_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_eof,
  input logic              rx_err,
  input logic [1:0]        rx_clr,
  input logic              rx_cap_valid,
  input logic              rx_cap_ovr,
  input logic [TIME_W-1:0] rx_cap_time,
  input logic [47:0]       rx_cap_uuid,
  input logic [15:0]       rx_cap_seq,
  input logic              tx_eof,
  input logic              tx_err,
  input logic [1:0]        tx_clr,
  input logic              tx_cap_valid,
  input logic              tx_cap_ovr,
  input logic [TIME_W-1:0] tx_cap_time,
  input logic [47:0]       tx_cap_uuid,
  input logic [15:0]       tx_cap_seq
);
  // R6
  rx_hold_until_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_eof |=> ($stable(rx_cap_time) && $stable(rx_cap_uuid) && $stable(rx_cap_seq)));
  // R6
  tx_hold_until_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_eof |=> ($stable(tx_cap_time) && $stable(tx_cap_uuid) && $stable(tx_cap_seq)));
  // R6
  rx_err_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eof && rx_err) |=> (!$rose(rx_cap_valid) && $stable(rx_cap_time)));
  // R6
  tx_err_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_eof && tx_err) |=> (!$rose(tx_cap_valid) && $stable(tx_cap_time)));
  // R8
  rx_ovr_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_cap_ovr) |-> $past(rx_cap_valid));
  // R8
  tx_ovr_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_cap_ovr) |-> $past(tx_cap_valid));
  // R9
  rx_clear_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clr[0] && !rx_eof) |=> !rx_cap_valid);
  // R9
  tx_clear_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_clr[0] && !tx_eof) |=> !tx_cap_valid);
  // R9
  rx_clear_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clr[1] && !rx_eof) |=> !rx_cap_ovr);
  // R9
  tx_clear_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_clr[1] && !tx_eof) |=> !tx_cap_ovr);
endmodule

bind ptp_ts_capture ptp_ts_capture_chk #(.TIME_W(TIME_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rx_eof(rx_eof), .rx_err(rx_err), .rx_clr(rx_clr),
  .rx_cap_valid(rx_cap_valid), .rx_cap_ovr(rx_cap_ovr), .rx_cap_time(rx_cap_time),
  .rx_cap_uuid(rx_cap_uuid), .rx_cap_seq(rx_cap_seq),
  .tx_eof(tx_eof), .tx_err(tx_err), .tx_clr(tx_clr),
  .tx_cap_valid(tx_cap_valid), .tx_cap_ovr(tx_cap_ovr), .tx_cap_time(tx_cap_time),
  .tx_cap_uuid(tx_cap_uuid), .tx_cap_seq(tx_cap_seq)
);

// File: tb/ptp_ts_capture_tb.sv
`timescale 1ns/1ps
module ptp_ts_capture_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        mode_master = 1'b0;
  logic [63:0] tnow = 64'hFFFF_FFF0_0000_0000;
  logic [1:0]  sfd = '0, vld = '0, eof = '0, err = '0;
  logic [7:0]  dat [2];
  logic [1:0]  clr [2];

  // outputs, index 0 = u_dut (HOST_SIDE=0), 1 = u_host (HOST_SIDE=1)
  logic [1:0]  rrdy, trdy;
  logic        cv [2][2];
  logic        co [2][2];
  logic [63:0] ct [2][2];
  logic [47:0] cu [2][2];
  logic [15:0] cs [2][2];

  int nchk = 0;
  int nfail = 0;
  logic [63:0] last_t [2][2];
  logic [47:0] last_u [2][2];
  logic [15:0] last_s [2][2];

  always @(negedge clk) tnow <= tnow + 64'h0000_0001_0000_0007;

  initial begin
    dat[0] = '0; dat[1] = '0; clr[0] = '0; clr[1] = '0;
  end

  ptp_ts_capture #(.HOST_SIDE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .time_now(tnow),
    .rx_sfd(sfd[0]), .rx_valid(vld[0]), .rx_ready(rrdy[0]), .rx_data(dat[0]),
    .rx_eof(eof[0]), .rx_err(err[0]), .rx_clr(clr[0]),
    .rx_cap_valid(cv[0][0]), .rx_cap_ovr(co[0][0]), .rx_cap_time(ct[0][0]),
    .rx_cap_uuid(cu[0][0]), .rx_cap_seq(cs[0][0]),
    .tx_sfd(sfd[1]), .tx_valid(vld[1]), .tx_ready(trdy[0]), .tx_data(dat[1]),
    .tx_eof(eof[1]), .tx_err(err[1]), .tx_clr(clr[1]),
    .tx_cap_valid(cv[0][1]), .tx_cap_ovr(co[0][1]), .tx_cap_time(ct[0][1]),
    .tx_cap_uuid(cu[0][1]), .tx_cap_seq(cs[0][1]));

  ptp_ts_capture #(.HOST_SIDE(1'b1)) u_host (
    .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .time_now(tnow),
    .rx_sfd(sfd[0]), .rx_valid(vld[0]), .rx_ready(rrdy[1]), .rx_data(dat[0]),
    .rx_eof(eof[0]), .rx_err(err[0]), .rx_clr(clr[0]),
    .rx_cap_valid(cv[1][0]), .rx_cap_ovr(co[1][0]), .rx_cap_time(ct[1][0]),
    .rx_cap_uuid(cu[1][0]), .rx_cap_seq(cs[1][0]),
    .tx_sfd(sfd[1]), .tx_valid(vld[1]), .tx_ready(trdy[1]), .tx_data(dat[1]),
    .tx_eof(eof[1]), .tx_err(err[1]), .tx_clr(clr[1]),
    .tx_cap_valid(cv[1][1]), .tx_cap_ovr(co[1][1]), .tx_cap_time(ct[1][1]),
    .tx_cap_uuid(cu[1][1]), .tx_cap_seq(cs[1][1]));

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fb(input int i, input int t, input int seed);
    if (i == 0) return {4'h5, 4'(t)};
    return 8'((seed * 7 + i * 13) & 255);
  endfunction

  function automatic logic [47:0] exp_uuid(input int seed);
    logic [47:0] u = '0;
    for (int k = 0; k < 6; k++) u = {u[39:0], fb(22 + k, 0, seed)};
    return u;
  endfunction

  function automatic logic [15:0] exp_seq(input int seed);
    return {fb(30, 0, seed), fb(31, 0, seed)};
  endfunction

  // start strobe and n bytes, no end
  task automatic partial(input int dir, input int n, input int t, input int seed, output logic [63:0] ts);
    @(negedge clk); sfd[dir] = 1'b1;
    @(posedge clk); ts = tnow;
    @(negedge clk); sfd[dir] = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i != 0) @(negedge clk);
      vld[dir] = 1'b1; dat[dir] = fb(i, t, seed);
    end
    @(negedge clk); vld[dir] = 1'b0;
  endtask

  // full frame; returns the time sampled at the start strobe
  task automatic frame(input int dir, input int t, input int seed, input int len,
                       input logic e, input logic gap, output logic [63:0] ts);
    @(negedge clk); sfd[dir] = 1'b1;
    @(posedge clk); ts = tnow;
    @(negedge clk); sfd[dir] = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (i != 0) @(negedge clk);
      if (gap && i == 10) begin
        vld[dir] = 1'b0; dat[dir] = 8'hEE;
        @(negedge clk);
      end
      vld[dir] = 1'b1; dat[dir] = fb(i, t, seed);
    end
    @(negedge clk); vld[dir] = 1'b0; eof[dir] = 1'b1; err[dir] = e;
    @(negedge clk); eof[dir] = 1'b0; err[dir] = 1'b0;
  endtask

  task automatic clear(input int dir, input logic [1:0] bits);
    @(negedge clk); clr[dir] = bits;
    @(negedge clk); clr[dir] = 2'b00;
  endtask

  // check both instances for one direction after a frame
  task automatic verify(input int dir, input int t, input int seed, input int len,
                        input logic e, input logic [63:0] ts, input string req);
    for (int inst = 0; inst < 2; inst++) begin
      logic role;
      logic [3:0] want;
      logic q;
      role = logic'(dir) ^ logic'(inst);        // R10: host instance swaps roles
      want = (mode_master ^ role) ? 4'd1 : 4'd0; // R2 / R3 table
      q = (4'(t) == want) && !e && (len >= 32);
      if (q) begin
        last_t[inst][dir] = ts;
        last_u[inst][dir] = exp_uuid(seed);
        last_s[inst][dir] = exp_seq(seed);
      end
      chk(req, $sformatf("valid inst%0d dir%0d type%0d", inst, dir, t), 64'(cv[inst][dir]), 64'(q));
      chk("R1", "time", ct[inst][dir], last_t[inst][dir]);
      chk("R5", "uuid", 64'(cu[inst][dir]), 64'(last_u[inst][dir]));
      chk("R5", "seq", 64'(cs[inst][dir]), 64'(last_s[inst][dir]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [63:0] ts, ts0;
    int seed = 3;
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++) begin
        last_t[a][b] = '0; last_u[a][b] = '0; last_s[a][b] = '0;
      end
    repeat (3) @(negedge clk);
    // R11 reset state
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++) begin
        chk("R11", "valid", 64'(cv[a][b]), 64'd0);
        chk("R11", "ovr", 64'(co[a][b]), 64'd0);
        chk("R11", "time", ct[a][b], 64'd0);
        chk("R11", "uuid", 64'(cu[a][b]), 64'd0);
      end
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rx ready", 64'(rrdy), 64'd3);

    // R2/R3/R4/R10 sweep: mode x dir x type x error, with gaps on odd seeds (R5)
    for (int m = 0; m < 2; m++)
      for (int dir = 0; dir < 2; dir++)
        for (int t = 0; t < 16; t++)
          for (int e = 0; e < 2; e++) begin
            mode_master = logic'(m);
            clear(dir, 2'b11);
            seed++;
            frame(dir, t, seed, 34, logic'(e), logic'(seed % 2), ts);
            verify(dir, t, seed, 34, logic'(e), ts, (t > 1) ? "R4" : (m == 0 ? "R2" : "R3"));
          end

    // R6 short frame: ends one byte before the last sequence byte
    mode_master = 1'b0;
    clear(0, 2'b11);
    seed++;
    frame(0, 0, seed, 31, 1'b0, 1'b0, ts);
    verify(0, 0, seed, 31, 1'b0, ts, "R6");

    // R7 restart mid-frame takes a new snapshot
    clear(0, 2'b11);
    seed++;
    partial(0, 12, 0, seed, ts0);
    frame(0, 0, seed, 34, 1'b0, 1'b0, ts);
    verify(0, 0, seed, 34, 1'b0, ts, "R7");
    chk("R7", "new snapshot differs", 64'(ts != ts0), 64'd1);

    // R8 overrun: second qualifying frame without clearing
    seed++;
    frame(0, 0, seed, 34, 1'b0, 1'b0, ts);
    verify(0, 0, seed, 34, 1'b0, ts, "R8");
    chk("R8", "dut ovr set", 64'(co[0][0]), 64'd1);
    chk("R8", "host ovr clear", 64'(co[1][0]), 64'd0);

    // R9 separate W1C bits
    clear(0, 2'b01);
    chk("R9", "valid cleared", 64'(cv[0][0]), 64'd0);
    chk("R9", "ovr kept", 64'(co[0][0]), 64'd1);
    clear(0, 2'b10);
    chk("R9", "ovr cleared", 64'(co[0][0]), 64'd0);
    chk("R9", "time kept", ct[0][0], last_t[0][0]);

    // R8 with master mode on tx for the host instance (receive role there)
    mode_master = 1'b1;
    clear(1, 2'b11);
    seed++;
    frame(1, 1, seed, 34, 1'b0, 1'b1, ts);
    verify(1, 1, seed, 34, 1'b0, ts, "R10");
    seed++;
    frame(1, 1, seed, 34, 1'b0, 1'b0, ts);
    verify(1, 1, seed, 34, 1'b0, ts, "R8");
    chk("R8", "host tx ovr", 64'(co[1][1]), 64'd1);
    chk("R8", "dut tx ovr", 64'(co[0][1]), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule